// File: doc/BRIEF.md
# Paged Monochrome Display Write Controller

This block is the write side of a 128 by 64 one-bit display. A processor reaches it through a small memory-mapped write port. A frame store of eight pages holds the picture. Each page is a row of 128 bytes, and each byte covers a vertical strip of eight pixels. A control word puts the block in one of three states: data, command, or an invalid state that ignores everything. Command bytes choose the page. Data bytes are stored one after another along the columns of the current page.

A scan-out engine reads the frame through a separate pixel port. It gives an x and a y coordinate and gets back one bit, with no wait states. Both read registers (interrupt control and status) return zero, and the block raises no interrupt.

Top module: `lcd_page_ctrl`

## Requirements
- R1: After reset the frame store is all zero, the column and page are 0, and the block is in the invalid state, so a data-register write stores nothing.
- R2: A write to offset 0x1AC selects the state. The full word 0x00100011 selects data and 0x00104011 selects command. Any other word selects invalid. No other write changes the state.
- R3: A write to offset 0x1BC whose full 32-bit word lies in 0xB0..0xB7 sets the page to word minus 0xB0 and the column to 0. Any other word there is ignored.
- R4: In command state, a write to the data offset 0x1C0 is treated exactly as in R3 and stores nothing.
- R5: In data state, a write to 0x1C0 stores bits [7:0] at byte page*128 + column, and the column then advances by one.
- R6: The column wraps from 127 to 0 without leaving the current page.
- R7: In invalid state, data-register writes store nothing and do not move the column.
- R8: pix_on equals bit (y mod 8) of byte x + (y/8)*128. It reflects a store from the cycle after that store's write edge.
- R9: bus_rdata is always zero. Writes to offsets 0x180 and 0x184 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, always zero |
| pix_x | input | 7 | Pixel column 0..127 |
| pix_y | input | 6 | Pixel row 0..63 |
| pix_on | output | 1 | Pixel value at (pix_x, pix_y) |

## Verification
The bench builds the block with its default geometry of 128 columns and 8 pages and the default control words. At this size the column wrap takes 129 back-to-back stores, which the bench can drive in full, and the top page (0xB7) can be reached. Both routes to a page change (the instruction register and the data register in command state) are checked. Out-of-range words such as 0x1B2 and 0xB8 are checked too, and the column position after each ignored write is recovered from where the next stored byte lands.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DATA = 2'd1,
    MODE_CMD  = 2'd2
  } lcd_mode_e;

  // Map a control word onto a state; unknown words fall to MODE_OFF.
  function automatic lcd_mode_e mode_from_word(input logic [31:0] w,
                                               input logic [31:0] data_w,
                                               input logic [31:0] cmd_w);
    if (w == data_w)     return MODE_DATA;
    else if (w == cmd_w) return MODE_CMD;
    else                 return MODE_OFF;
  endfunction

  // Page command test on the whole word.
  function automatic logic is_page_cmd(input logic [31:0] w,
                                       input logic [31:0] base,
                                       input int unsigned pages);
    return (w >= base) && (w < base + pages);
  endfunction

  function automatic int unsigned page_of(input logic [31:0] w,
                                          input logic [31:0] base);
    return int'(w - base);
  endfunction

  // Linear byte address of a page/column pair.
  function automatic int unsigned byte_index(input int unsigned page,
                                             input int unsigned col,
                                             input int unsigned cols);
    return page * cols + col;
  endfunction

endpackage

// File: rtl/lcd_mode_reg.sv
module lcd_mode_reg
  import lcd_pkg::*;
#(
  parameter logic [31:0] DATA_WORD = 32'h0010_0011,
  parameter logic [31:0] CMD_WORD  = 32'h0010_4011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_mode,
  input  logic [31:0] word,
  output lcd_mode_e   mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= MODE_OFF;
    else if (wr_mode) mode_q <= mode_from_word(word, DATA_WORD, CMD_WORD);
  end

  // R2: state only moves on a control-register write
  a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));

  // R2: an unknown control word always lands in the invalid state
  a_r2_bad_word: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && word != DATA_WORD && word != CMD_WORD) |=> mode_q == MODE_OFF);

endmodule

// File: rtl/lcd_cursor.sv
module lcd_cursor #(
  parameter int unsigned COLS   = 128,
  parameter int unsigned PAGES  = 8,
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned PAGE_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_set,
  input  logic [PAGE_W-1:0] new_page,
  input  logic              store_en,
  output logic [PAGE_W-1:0] page_q,
  output logic [COL_W-1:0]  col_q
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic col_wrap;
  assign col_wrap = (col_q == LAST_COL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      col_q  <= '0;
    end else if (page_set) begin
      page_q <= new_page;
      col_q  <= '0;
    end else if (store_en) begin
      col_q <= col_wrap ? '0 : col_q + 1'b1;
    end
  end

  // R3: a page command lands the cursor at column 0 of the chosen page
  a_r3_page_home: assert property (@(posedge clk) disable iff (!rst_n)
    page_set |=> (col_q == '0) && (page_q == $past(new_page)));

  // R5: a store advances the column by exactly one
  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !page_set && !col_wrap) |=> col_q == $past(col_q) + 1'b1);

  // R6: the last column wraps to 0 and keeps the page
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && !page_set && col_wrap) |=> (col_q == '0) && $stable(page_q));

  // R7: with no store and no command the cursor does not move
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!store_en && !page_set) |=> $stable(col_q) && $stable(page_q));

endmodule

// File: rtl/lcd_frame_mem.sv
module lcd_frame_mem
  import lcd_pkg::*;
#(
  parameter int unsigned COLS  = 128,
  parameter int unsigned PAGES = 8,
  localparam int unsigned BYTES  = COLS * PAGES,
  localparam int unsigned ADDR_W = $clog2(BYTES),
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned PAGE_W = $clog2(PAGES),
  localparam int unsigned Y_W    = PAGE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_en,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic [7:0]        store_byte,
  input  logic [COL_W-1:0]  pix_x,
  input  logic [Y_W-1:0]    pix_y,
  output logic              pix_on
);

  logic [7:0] mem_q [BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(BYTES); i++) mem_q[i] <= '0;
    end else if (store_en) begin
      mem_q[store_addr] <= store_byte;
    end
  end

  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_byte;

  assign rd_addr = ADDR_W'(byte_index(int'(pix_y[Y_W-1:3]), int'(pix_x), COLS));
  assign rd_byte = mem_q[rd_addr];
  assign pix_on  = rd_byte[pix_y[2:0]];

  // R8: a stored byte is present at its address on the next cycle
  a_r8_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    store_en |=> mem_q[$past(store_addr)] == $past(store_byte));

endmodule

// File: rtl/lcd_page_ctrl.sv
module lcd_page_ctrl
  import lcd_pkg::*;
#(
  parameter int unsigned COLS       = 128,
  parameter int unsigned PAGES      = 8,
  parameter logic [31:0] DATA_WORD  = 32'h0010_0011,
  parameter logic [31:0] CMD_WORD   = 32'h0010_4011,
  parameter logic [31:0] PAGE_BASE  = 32'h0000_00B0,
  parameter logic [11:0] OFS_IRQ_EN = 12'h180,
  parameter logic [11:0] OFS_IRQ_ST = 12'h184,
  parameter logic [11:0] OFS_MODE   = 12'h1AC,
  parameter logic [11:0] OFS_INSTR  = 12'h1BC,
  parameter logic [11:0] OFS_DATA   = 12'h1C0,
  localparam int unsigned COL_W  = $clog2(COLS),
  localparam int unsigned PAGE_W = $clog2(PAGES),
  localparam int unsigned ADDR_W = $clog2(COLS * PAGES),
  localparam int unsigned Y_W    = PAGE_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [COL_W-1:0]  pix_x,
  input  logic [Y_W-1:0]    pix_y,
  output logic              pix_on
);

  // Decoded bus events
  logic wr_mode, wr_instr, wr_data, wr_irq;
  assign wr_mode  = bus_wr && (bus_addr == OFS_MODE);
  assign wr_instr = bus_wr && (bus_addr == OFS_INSTR);
  assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
  assign wr_irq   = bus_wr && ((bus_addr == OFS_IRQ_EN) || (bus_addr == OFS_IRQ_ST));

  lcd_mode_e         mode_q;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;

  // Named internal events
  logic              cmd_src;
  logic              page_set;
  logic              store_en;
  logic [PAGE_W-1:0] new_page;
  logic [ADDR_W-1:0] store_addr;

  assign cmd_src    = wr_instr || (wr_data && mode_q == MODE_CMD);
  assign page_set   = cmd_src && is_page_cmd(bus_wdata, PAGE_BASE, PAGES);
  assign new_page   = PAGE_W'(page_of(bus_wdata, PAGE_BASE));
  assign store_en   = wr_data && (mode_q == MODE_DATA);
  assign store_addr = ADDR_W'(byte_index(int'(page_q), int'(col_q), COLS));

  // Both interrupt registers read as zero; nothing else is readable.
  assign bus_rdata = '0;

  lcd_mode_reg #(
    .DATA_WORD (DATA_WORD),
    .CMD_WORD  (CMD_WORD)
  ) mode_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mode (wr_mode),
    .word    (bus_wdata),
    .mode_q  (mode_q)
  );

  lcd_cursor #(
    .COLS  (COLS),
    .PAGES (PAGES)
  ) cursor_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .page_set (page_set),
    .new_page (new_page),
    .store_en (store_en),
    .page_q   (page_q),
    .col_q    (col_q)
  );

  lcd_frame_mem #(
    .COLS  (COLS),
    .PAGES (PAGES)
  ) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .store_en   (store_en),
    .store_addr (store_addr),
    .store_byte (bus_wdata[7:0]),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .pix_on     (pix_on)
  );

  // R4: a data-register write never both stores and sets the page
  a_r4_cmd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(store_en && page_set));

  // R9: interrupt register writes leave the cursor where it was
  a_r9_irq_inert: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq |=> $stable(col_q) && $stable(page_q));

  // R1: the state is invalid on the first cycle after reset
  a_r1_reset_mode: assert property (@(posedge clk)
    !rst_n |=> mode_q == MODE_OFF);

endmodule

// File: tb/lcd_page_ctrl_tb.sv
module lcd_page_ctrl_tb_top;

  localparam logic [11:0] A_IRQE  = 12'h180;
  localparam logic [11:0] A_IRQS  = 12'h184;
  localparam logic [11:0] A_MODE  = 12'h1AC;
  localparam logic [11:0] A_INSTR = 12'h1BC;
  localparam logic [11:0] A_DATA  = 12'h1C0;
  localparam logic [31:0] W_DATA  = 32'h0010_0011;
  localparam logic [31:0] W_CMD   = 32'h0010_4011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  pix_x = '0;
  logic [5:0]  pix_y = '0;
  logic        pix_on;

  always #5 clk = ~clk;

  lcd_page_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .pix_on    (pix_on)
  );

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic        chk;
    logic [11:0] addr;
    logic [31:0] data;
    logic [6:0]  x;
    logic [5:0]  y;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{1'b0, A_MODE,  W_DATA,        7'd0, 6'd0,  1'b0, 4'd2},
    '{1'b0, A_DATA,  32'h81,        7'd0, 6'd0,  1'b0, 4'd5},
    '{1'b0, A_DATA,  32'h02,        7'd0, 6'd0,  1'b0, 4'd5},
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd0,  1'b1, 4'd5},  // R5 bit0
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd7,  1'b1, 4'd8},  // R8 bit7
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd1,  1'b0, 4'd8},
    '{1'b1, 12'h0,   32'h0,         7'd1, 6'd1,  1'b1, 4'd5},  // R5 next col
    '{1'b0, A_INSTR, 32'hB3,        7'd0, 6'd0,  1'b0, 4'd3},
    '{1'b0, A_DATA,  32'hFF,        7'd0, 6'd0,  1'b0, 4'd5},
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd24, 1'b1, 4'd3},  // R3 page 3
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd31, 1'b1, 4'd8},
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd32, 1'b0, 4'd8},
    '{1'b0, A_MODE,  W_CMD,         7'd0, 6'd0,  1'b0, 4'd2},
    '{1'b0, A_DATA,  32'hB7,        7'd0, 6'd0,  1'b0, 4'd4},
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd56, 1'b0, 4'd4},  // R4 no store
    '{1'b0, A_MODE,  W_DATA,        7'd0, 6'd0,  1'b0, 4'd2},
    '{1'b0, A_DATA,  32'h10,        7'd0, 6'd0,  1'b0, 4'd5},
    '{1'b1, 12'h0,   32'h0,         7'd0, 6'd60, 1'b1, 4'd4},  // R4 page 7
    '{1'b0, A_MODE,  32'h1234_5678, 7'd0, 6'd0,  1'b0, 4'd2},
    '{1'b0, A_DATA,  32'hFF,        7'd0, 6'd0,  1'b0, 4'd7},
    '{1'b1, 12'h0,   32'h0,         7'd1, 6'd57, 1'b0, 4'd7},  // R7 ignored
    '{1'b0, A_MODE,  W_DATA,        7'd0, 6'd0,  1'b0, 4'd2},
    '{1'b0, A_DATA,  32'h01,        7'd0, 6'd0,  1'b0, 4'd7},
    '{1'b1, 12'h0,   32'h0,         7'd1, 6'd56, 1'b1, 4'd7},  // R7 col kept
    '{1'b0, A_INSTR, 32'h1B2,       7'd0, 6'd0,  1'b0, 4'd3},
    '{1'b0, A_DATA,  32'h01,        7'd0, 6'd0,  1'b0, 4'd3},
    '{1'b1, 12'h0,   32'h0,         7'd2, 6'd56, 1'b1, 4'd3},  // R3 0x1B2 ignored
    '{1'b0, A_INSTR, 32'hB8,        7'd0, 6'd0,  1'b0, 4'd3},
    '{1'b0, A_IRQE,  32'hB1,        7'd0, 6'd0,  1'b0, 4'd9},
    '{1'b0, A_DATA,  32'h01,        7'd0, 6'd0,  1'b0, 4'd9}
  };

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic chk_pix(input logic [6:0] x, input logic [5:0] y,
                         input logic exp, input string req);
    @(negedge clk);
    pix_x = x;
    pix_y = y;
    #1;
    checks++;
    if (pix_on !== exp) begin
      errors++;
      $display("FAIL %s pixel (%0d,%0d): actual=%0b expected=%0b", req, x, y, pix_on, exp);
    end
  endtask

  task automatic chk_rdata(input logic [11:0] a, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL %s rdata at %0h: actual=%0h expected=0", req, a, bus_rdata);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared frame, invalid state
    chk_pix(7'd0, 6'd0, 1'b0, "R1");
    chk_pix(7'd127, 6'd63, 1'b0, "R1");
    wr(A_DATA, 32'hFF);
    chk_pix(7'd0, 6'd0, 1'b0, "R1");
    chk_rdata(A_IRQS, "R9");
    chk_rdata(A_IRQE, "R9");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].chk)
        chk_pix(VEC[i].x, VEC[i].y, VEC[i].exp, $sformatf("R%0d", VEC[i].req));
      else
        wr(VEC[i].addr, VEC[i].data);
    end
    // R3: 0xB8 ignored, R9: irq write ignored -> last store went to col 3 of page 7
    chk_pix(7'd3, 6'd56, 1'b1, "R9");
    chk_pix(7'd3, 6'd8, 1'b0, "R3");

    // R6: 129 stores on page 5 wrap to column 0
    wr(A_INSTR, 32'hB5);
    for (int c = 0; c < 128; c++) wr(A_DATA, 32'h01);
    chk_pix(7'd127, 6'd40, 1'b1, "R6");
    wr(A_DATA, 32'h80);
    chk_pix(7'd0, 6'd47, 1'b1, "R6");
    chk_pix(7'd0, 6'd40, 1'b0, "R6");
    chk_pix(7'd0, 6'd48, 1'b0, "R6");
    chk_pix(7'd1, 6'd40, 1'b1, "R6");

    // R1: reset mid-run clears the frame and the state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk_pix(7'd0, 6'd24, 1'b0, "R1");
    chk_pix(7'd0, 6'd60, 1'b0, "R1");
    wr(A_DATA, 32'hFF);
    chk_pix(7'd0, 6'd0, 1'b0, "R1");

    finish_run();
  end

endmodule